// File: doc/BRIEF.md
# eCPRI Message Traffic Generator and Checker

This block produces a stream of application-level eCPRI messages on a 64-bit valid/ready packet interface with start-of-packet, end-of-packet and empty-byte markers. Every message carries a 4-byte common header, a 2-byte flow identifier and a 2-byte sequence number, followed by a payload whose bytes count upward from the low byte of the sequence number. A companion checker watches the looped-back receive stream, rebuilds the message it expects and counts good and bad packets. It also raises a sticky error flag.

Two profiles are offered. The real-time control profile sends message type 2 with 72 payload bytes, and its packets follow one another with no idle cycle. The IQ-data profile sends message type 0 with 240 payload bytes and leaves a fixed number of idle cycles after each packet. A small register port starts and stops traffic, chooses continuous or fixed-count operation, sets the packet count and returns the statistics. Byte 0 of a beat is carried on `tx_data[63:56]`.

Register map (word address on `reg_addr`):
- 0 control. Writing bit 0 starts traffic. Writing bit 1 stops traffic. Writing bit 4 clears the error flag. Bit 2 selects continuous mode and bit 3 selects the IQ profile; these two bits read back.
- 1 packet count for fixed-count mode, 16 bits.
- 2 transmitted packets.
- 3 good received packets.
- 4 bad received packets.
- 5 status: bit 0 is busy, bit 1 is the sticky error flag.

Top module: `ecpri_tgc`

## Requirements
- R1: After reset, `tx_valid` is low and register addresses 2, 3, 4 and 5 all read 0.
- R2: Beat 0 of each message carries the following bytes, first byte on `tx_data[63:56]`:
  - byte 0 is 0x10 (revision 1, reserved bits 0, concatenation 0);
  - byte 1 is the message type;
  - bytes 2 and 3 are the payload byte count, high byte first;
  - bytes 4 and 5 are `FLOW_ID`, high byte first;
  - bytes 6 and 7 are the sequence number, high byte first.
- R3: With control bit 3 at 0, messages have type 2 and a 72-byte payload. That is 10 beats with empty 0 on the last beat. While more packets are due and `tx_ready` stays high, the next start-of-packet follows an end-of-packet with no idle cycle.
- R4: With control bit 3 at 1, messages have type 0 and a 240-byte payload. That is 31 beats with empty 0 on the last beat. After every end-of-packet, `tx_valid` stays low for exactly `GAP_CYCLES` cycles before the next start-of-packet.
- R5: Payload byte k, counting from 0 just after the sequence field, equals (low byte of the sequence number + k) mod 256.
- R6: A start resets the sequence number to 0. The sequence number then rises by one per packet, modulo 65536.
- R7: With control bit 2 at 0, a start sends exactly the number of packets held at address 1 and then clears busy. A count of 0 sends nothing.
- R8: With control bit 2 at 1, traffic runs until a stop is written. The packet in flight is completed, so no partial packet is left.
- R9: While `tx_valid` is high and `tx_ready` is low, the data, markers and empty field stay stable. No beat is dropped or repeated.
- R10: Address 2 counts completed transmitted packets and address 3 counts received packets that match exactly. A start clears both.
- R11: A received packet with any header, length, marker or payload mismatch adds one to address 4 and sets status bit 1. Writing control bit 4 clears status bit 1 but leaves the counts unchanged.
- R12: Writes to control bits 2 and 3 while busy is set are ignored. Address 0 keeps reading the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit beat accepted |
| tx_sop | output | 1 | First beat of message |
| tx_eop | output | 1 | Last beat of message |
| tx_empty | output | 3 | Unused bytes in last beat |
| tx_data | output | 64 | Transmit data |
| rx_valid | input | 1 | Receive beat valid |
| rx_sop | input | 1 | Receive first beat |
| rx_eop | input | 1 | Receive last beat |
| rx_empty | input | 3 | Receive unused bytes in last beat |
| rx_data | input | 64 | Receive data |

## Verification
The assertions assume three things about the inputs:
- the receive stream carries only beats that the transmit side actually handed over;
- a start is written only while busy is clear;
- the profile is not expected to change mid-run, which the register block enforces itself.

The stimulus keeps to these assumptions. It loops the transmit stream back to the receive side through the handshake only. It waits for busy to clear before each new start. It toggles `tx_ready` from a seeded random source, so every stall case arises without the bench having to break the hold rule. Errors are injected by flipping a bit on the receive copy, and the transmit side is left untouched.

// File: rtl/ecpri_tg_pkg.sv
package ecpri_tg_pkg;

    localparam int unsigned LANES = 8;
    localparam logic [7:0] MT_IQ  = 8'd0;
    localparam logic [7:0] MT_RTC = 8'd2;
    localparam logic [7:0] HDR_B0 = 8'h10;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_SEND = 2'd1,
        GS_GAP  = 2'd2
    } gen_state_e;

    typedef struct packed {
        logic [7:0]  mtype;
        logic [15:0] plen;
    } profile_t;

    function automatic profile_t pick_profile(input logic iq, input logic [15:0] rtc_len,
                                              input logic [15:0] iq_len);
        profile_t p;
        p.mtype = iq ? MT_IQ : MT_RTC;
        p.plen  = iq ? iq_len : rtc_len;
        return p;
    endfunction

    function automatic logic [7:0] msg_byte(input profile_t p, input logic [15:0] fid,
                                            input logic [15:0] seq, input logic [15:0] idx);
        logic [7:0] b;
        case (idx)
            16'd0:   b = HDR_B0;
            16'd1:   b = p.mtype;
            16'd2:   b = p.plen[15:8];
            16'd3:   b = p.plen[7:0];
            16'd4:   b = fid[15:8];
            16'd5:   b = fid[7:0];
            16'd6:   b = seq[15:8];
            16'd7:   b = seq[7:0];
            default: b = seq[7:0] + idx[7:0] - 8'd8;
        endcase
        return b;
    endfunction

    function automatic logic [63:0] make_beat(input profile_t p, input logic [15:0] fid,
                                              input logic [15:0] seq, input logic [7:0] bidx);
        logic [63:0] d;
        logic [15:0] pos;
        logic [15:0] total;
        total = p.plen + 16'd8;
        d = '0;
        for (int l = 0; l < LANES; l++) begin
            pos = {5'd0, bidx, 3'd0} + 16'(l);
            d[63-8*l -: 8] = (pos < total) ? msg_byte(p, fid, seq, pos) : 8'h00;
        end
        return d;
    endfunction

    function automatic logic [7:0] last_beat(input profile_t p);
        logic [15:0] t;
        t = ((p.plen + 16'd15) >> 3) - 16'd1;
        return t[7:0];
    endfunction

    function automatic logic [2:0] empty_of(input profile_t p);
        logic [15:0] t;
        logic [3:0]  e;
        t = p.plen + 16'd8;
        e = 4'd8 - {1'b0, t[2:0]};
        return e[2:0];
    endfunction

endpackage

// File: rtl/ecpri_tg_regs.sv
module ecpri_tg_regs
    import ecpri_tg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             start_p,
    output logic             stop_p,
    output logic             clr_err_p,
    output logic             cont_q,
    output logic             prof_q,
    output logic [15:0]      target_q,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] good_cnt,
    input  logic [CNT_W-1:0] bad_cnt,
    input  logic             busy,
    input  logic             err_flag
);

    logic ctrl_wr;
    assign ctrl_wr   = reg_wr && (reg_addr == 3'd0);
    assign start_p   = ctrl_wr && reg_wdata[0] && !busy;
    assign stop_p    = ctrl_wr && reg_wdata[1];
    assign clr_err_p = ctrl_wr && reg_wdata[4];

    always_ff @(posedge clk) begin
        if (rst) begin
            cont_q   <= 1'b0;
            prof_q   <= 1'b0;
            target_q <= '0;
        end else begin
            if (ctrl_wr && !busy) begin
                cont_q <= reg_wdata[2];
                prof_q <= reg_wdata[3];
            end
            if (reg_wr && (reg_addr == 3'd1)) begin
                target_q <= reg_wdata;
            end
        end
    end

    always_comb begin
        case (reg_addr)
            3'd0:    reg_rdata = {28'd0, prof_q, cont_q, 2'b00};
            3'd1:    reg_rdata = {16'd0, target_q};
            3'd2:    reg_rdata = 32'(tx_cnt);
            3'd3:    reg_rdata = 32'(good_cnt);
            3'd4:    reg_rdata = 32'(bad_cnt);
            3'd5:    reg_rdata = {30'd0, err_flag, busy};
            default: reg_rdata = 32'd0;
        endcase
    end

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(cont_q) && $stable(prof_q))); // R12

endmodule

// File: rtl/ecpri_tg_gen.sv
module ecpri_tg_gen
    import ecpri_tg_pkg::*;
#(
    parameter int          GAP_CYCLES = 2,
    parameter logic [15:0] FLOW_ID    = 16'h5A01,
    parameter logic [15:0] RTC_BYTES  = 16'd72,
    parameter logic [15:0] IQ_BYTES   = 16'd240,
    parameter int          CNT_W      = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic             cont,
    input  logic             prof,
    input  logic [15:0]      target,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic             tx_sop,
    output logic             tx_eop,
    output logic [2:0]       tx_empty,
    output logic [63:0]      tx_data,
    output logic [CNT_W-1:0] tx_cnt,
    output logic             busy
);

    localparam int GAP_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

    gen_state_e       state;
    logic [7:0]       idx;
    logic [15:0]      seq;
    logic [15:0]      sent;
    logic             run;
    logic [GAP_W-1:0] gap_cnt;

    profile_t   prof_cfg;
    logic [7:0] last;
    logic       fire;
    logic       at_end;
    logic       run_keep;
    logic       more_now;
    logic       more_end;
    logic       gap_en;

    generate
        if (GAP_CYCLES > 0) begin : g_gap
            assign gap_en = prof;
        end else begin : g_nogap
            assign gap_en = 1'b0;
        end
    endgenerate

    assign prof_cfg = pick_profile(prof, RTC_BYTES, IQ_BYTES);
    assign last     = last_beat(prof_cfg);
    assign tx_valid = (state == GS_SEND);
    assign tx_sop   = tx_valid && (idx == 8'd0);
    assign tx_eop   = tx_valid && (idx == last);
    assign tx_empty = tx_eop ? empty_of(prof_cfg) : 3'd0;
    assign tx_data  = make_beat(prof_cfg, FLOW_ID, seq, idx);
    assign fire     = tx_valid && tx_ready;
    assign at_end   = fire && (idx == last);
    assign run_keep = run && !stop;
    assign more_now = run_keep && (cont || (sent < target));
    assign more_end = run_keep && (cont || ((sent + 16'd1) < target));
    assign busy     = run || (state != GS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= GS_IDLE;
            idx     <= '0;
            seq     <= '0;
            sent    <= '0;
            run     <= 1'b0;
            gap_cnt <= '0;
            tx_cnt  <= '0;
        end else begin
            if (stop) begin
                run <= 1'b0;
            end
            case (state)
                GS_IDLE: begin
                    if (start && !run) begin
                        run    <= 1'b1;
                        sent   <= '0;
                        seq    <= '0;
                        tx_cnt <= '0;
                    end else if (more_now) begin
                        state <= GS_SEND;
                        idx   <= '0;
                    end else if (run) begin
                        run <= 1'b0;
                    end
                end
                GS_SEND: begin
                    if (fire) begin
                        if (at_end) begin
                            idx    <= '0;
                            seq    <= seq + 16'd1;
                            sent   <= sent + 16'd1;
                            tx_cnt <= tx_cnt + 1'b1;
                            if (gap_en) begin
                                state   <= GS_GAP;
                                gap_cnt <= '0;
                            end else if (!more_end) begin
                                state <= GS_IDLE;
                            end
                        end else begin
                            idx <= idx + 8'd1;
                        end
                    end
                end
                GS_GAP: begin
                    if (gap_cnt == GAP_W'(GAP_CYCLES - 1)) begin
                        state <= more_now ? GS_SEND : GS_IDLE;
                        idx   <= '0;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= GS_IDLE;
            endcase
        end
    end

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop)
                                     && $stable(tx_eop) && $stable(tx_empty))); // R9

    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (fire && tx_eop && !prof && cont && run && !stop) |=> tx_valid); // R3

    AST_GAP_AFTER_EOP: assert property (@(posedge clk) disable iff (rst)
        (fire && tx_eop && gap_en) |=> !tx_valid); // R4

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (tx_cnt == '0 && !tx_valid)); // R10

endmodule

// File: rtl/ecpri_tg_chk.sv
module ecpri_tg_chk
    import ecpri_tg_pkg::*;
#(
    parameter logic [15:0] FLOW_ID   = 16'h5A01,
    parameter logic [15:0] RTC_BYTES = 16'd72,
    parameter logic [15:0] IQ_BYTES  = 16'd240,
    parameter int          CNT_W     = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             clr_err,
    input  logic             prof,
    input  logic             rx_valid,
    input  logic             rx_sop,
    input  logic             rx_eop,
    input  logic [2:0]       rx_empty,
    input  logic [63:0]      rx_data,
    output logic [CNT_W-1:0] good_cnt,
    output logic [CNT_W-1:0] bad_cnt,
    output logic             err_flag
);

    logic [7:0]  idx;
    logic [15:0] exp_seq;
    logic        bad_acc;

    profile_t    prof_cfg;
    logic [7:0]  last;
    logic [63:0] exp_data;
    logic        mism;
    logic        fin;
    logic        bad_now;

    assign prof_cfg = pick_profile(prof, RTC_BYTES, IQ_BYTES);
    assign last     = last_beat(prof_cfg);
    assign exp_data = make_beat(prof_cfg, FLOW_ID, exp_seq, idx);
    assign mism     = (rx_data != exp_data)
                    || (rx_sop != (idx == 8'd0))
                    || (rx_eop != (idx == last))
                    || (rx_eop && (rx_empty != empty_of(prof_cfg)));
    assign fin      = rx_eop || (idx == last);
    assign bad_now  = bad_acc || mism;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx      <= '0;
            exp_seq  <= '0;
            bad_acc  <= 1'b0;
            good_cnt <= '0;
            bad_cnt  <= '0;
            err_flag <= 1'b0;
        end else begin
            if (clear) begin
                idx      <= '0;
                exp_seq  <= '0;
                bad_acc  <= 1'b0;
                good_cnt <= '0;
                bad_cnt  <= '0;
            end else if (rx_valid) begin
                if (fin) begin
                    idx     <= '0;
                    exp_seq <= exp_seq + 16'd1;
                    bad_acc <= 1'b0;
                    if (bad_now) begin
                        bad_cnt <= bad_cnt + 1'b1;
                    end else begin
                        good_cnt <= good_cnt + 1'b1;
                    end
                end else begin
                    idx     <= idx + 8'd1;
                    bad_acc <= bad_now;
                end
            end
            if (clr_err) begin
                err_flag <= 1'b0;
            end
            if (!clear && rx_valid && fin && bad_now) begin
                err_flag <= 1'b1;
            end
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !clr_err) |=> err_flag); // R11

    AST_GOOD_STEP: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (good_cnt == $past(good_cnt) || good_cnt == $past(good_cnt) + 1'b1)); // R10

    AST_BAD_STEP: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (bad_cnt == $past(bad_cnt) || bad_cnt == $past(bad_cnt) + 1'b1)); // R11

endmodule

// File: rtl/ecpri_tgc.sv
module ecpri_tgc
    import ecpri_tg_pkg::*;
#(
    parameter int          GAP_CYCLES = 2,
    parameter logic [15:0] FLOW_ID    = 16'h5A01,
    parameter logic [15:0] RTC_BYTES  = 16'd72,
    parameter logic [15:0] IQ_BYTES   = 16'd240,
    parameter int          CNT_W      = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic        tx_sop,
    output logic        tx_eop,
    output logic [2:0]  tx_empty,
    output logic [63:0] tx_data,
    input  logic        rx_valid,
    input  logic        rx_sop,
    input  logic        rx_eop,
    input  logic [2:0]  rx_empty,
    input  logic [63:0] rx_data
);

    logic             start_p;
    logic             stop_p;
    logic             clr_err_p;
    logic             cont_q;
    logic             prof_q;
    logic [15:0]      target_q;
    logic [CNT_W-1:0] tx_cnt;
    logic [CNT_W-1:0] good_cnt;
    logic [CNT_W-1:0] bad_cnt;
    logic             busy;
    logic             err_flag;

    ecpri_tg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .start_p   (start_p),
        .stop_p    (stop_p),
        .clr_err_p (clr_err_p),
        .cont_q    (cont_q),
        .prof_q    (prof_q),
        .target_q  (target_q),
        .tx_cnt    (tx_cnt),
        .good_cnt  (good_cnt),
        .bad_cnt   (bad_cnt),
        .busy      (busy),
        .err_flag  (err_flag)
    );

    ecpri_tg_gen #(
        .GAP_CYCLES (GAP_CYCLES),
        .FLOW_ID    (FLOW_ID),
        .RTC_BYTES  (RTC_BYTES),
        .IQ_BYTES   (IQ_BYTES),
        .CNT_W      (CNT_W)
    ) u_gen (
        .clk      (clk),
        .rst      (rst),
        .start    (start_p),
        .stop     (stop_p),
        .cont     (cont_q),
        .prof     (prof_q),
        .target   (target_q),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_sop   (tx_sop),
        .tx_eop   (tx_eop),
        .tx_empty (tx_empty),
        .tx_data  (tx_data),
        .tx_cnt   (tx_cnt),
        .busy     (busy)
    );

    ecpri_tg_chk #(
        .FLOW_ID   (FLOW_ID),
        .RTC_BYTES (RTC_BYTES),
        .IQ_BYTES  (IQ_BYTES),
        .CNT_W     (CNT_W)
    ) u_chk (
        .clk      (clk),
        .rst      (rst),
        .clear    (start_p),
        .clr_err  (clr_err_p),
        .prof     (prof_q),
        .rx_valid (rx_valid),
        .rx_sop   (rx_sop),
        .rx_eop   (rx_eop),
        .rx_empty (rx_empty),
        .rx_data  (rx_data),
        .good_cnt (good_cnt),
        .bad_cnt  (bad_cnt),
        .err_flag (err_flag)
    );

endmodule

// File: tb/ecpri_tgc_tb.sv
module ecpri_tgc_tb;

    localparam int FID = 'h5A01;
    localparam int GAP = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [31:0] reg_rdata;
    logic        tx_valid, tx_sop, tx_eop;
    logic [2:0]  tx_empty;
    logic [63:0] tx_data;
    logic        tx_ready = 1'b1;
    logic        inject = 1'b0;
    logic        rdy_rand = 1'b0;

    ecpri_tgc u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .tx_empty(tx_empty), .tx_data(tx_data),
        .rx_valid(tx_valid && tx_ready), .rx_sop(tx_sop), .rx_eop(tx_eop),
        .rx_empty(tx_empty), .rx_data(tx_data ^ ((inject && tx_sop) ? 64'h1 : 64'h0))
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // monitor state
    bit          mon_iq = 0;
    int          mon_seq = 0, mon_idx = 0, mon_pkts = 0, mon_beats = 0;
    int          beat_err = 0, hold_err = 0;
    int          idle_run = 0, gap_min = 1000, gap_max = -1;
    bit          seen_pkt = 0, mon_stall = 0, got_first = 0;
    logic [63:0] stall_data, first_sop, last_b1;
    int          last_seq = -1;

    function automatic int plen_of(bit iq);
        return iq ? 240 : 72;
    endfunction

    function automatic int bbyte(bit iq, int seq, int k);
        case (k)
            0: return 'h10;
            1: return iq ? 0 : 2;
            2: return plen_of(iq) >> 8;
            3: return plen_of(iq) & 255;
            4: return FID >> 8;
            5: return FID & 255;
            6: return (seq >> 8) & 255;
            7: return seq & 255;
            default: return (seq + k - 8) & 255;
        endcase
    endfunction

    function automatic logic [63:0] bbeat(bit iq, int seq, int b);
        logic [63:0] d = '0;
        for (int l = 0; l < 8; l++) begin
            if (b * 8 + l < plen_of(iq) + 8) d[63-8*l -: 8] = 8'(bbyte(iq, seq, b * 8 + l));
        end
        return d;
    endfunction

    always begin
        @(posedge clk);
        #2;
        tx_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            int lastb;
            lastb = (plen_of(mon_iq) + 15) / 8 - 1;
            if (mon_stall && (!tx_valid || tx_data !== stall_data)) hold_err++;
            mon_stall  = tx_valid && !tx_ready;
            stall_data = tx_data;
            if (tx_valid && tx_ready) begin
                mon_beats++;
                if (tx_data !== bbeat(mon_iq, mon_seq, mon_idx) || tx_sop !== (mon_idx == 0)
                    || tx_eop !== (mon_idx == lastb) || (tx_eop && tx_empty !== 3'd0))
                    beat_err++;
                if (mon_idx == 0) begin
                    if (seen_pkt) begin
                        if (idle_run < gap_min) gap_min = idle_run;
                        if (idle_run > gap_max) gap_max = idle_run;
                    end
                    if (!got_first) begin first_sop = tx_data; got_first = 1; end
                    last_seq = int'(tx_data[15:0]);
                end
                if (mon_idx == 1) last_b1 = tx_data;
                if (mon_idx == lastb) begin
                    mon_idx = 0; mon_seq = (mon_seq + 1) & 'hFFFF; mon_pkts++;
                    seen_pkt = 1; idle_run = 0;
                end else mon_idx++;
            end else if (!tx_valid) idle_run++;
        end
    end

    task automatic mon_clear(input bit iq);
        mon_iq = iq; mon_seq = 0; mon_idx = 0; mon_pkts = 0; mon_beats = 0;
        beat_err = 0; hold_err = 0; idle_run = 0; gap_min = 1000; gap_max = -1;
        seen_pkt = 0; got_first = 0; last_seq = -1;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd5, s);
            if (!s[0]) break;
        end
    endtask

    task automatic run_fixed(input bit iq, input int n);
        wr(3'd1, 16'(n));
        mon_clear(iq);
        wr(3'd0, {12'd0, iq, 1'b0, 2'b01});
        wait_idle();
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7331));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        check("R1 tx_valid", tx_valid, 0);
        rd(3'd2, v); check("R1 tx count", v, 0);
        rd(3'd3, v); check("R1 good count", v, 0);
        rd(3'd4, v); check("R1 bad count", v, 0);
        rd(3'd5, v); check("R1 status", v, 0);

        // control profile, fixed count 3, ready high
        run_fixed(1'b0, 3);
        rd(3'd2, v); check("R7 tx count rtc", v, 3);
        rd(3'd3, v); check("R10 good count rtc", v, 3);
        rd(3'd4, v); check("R11 no bad rtc", v, 0);
        check("R2 rtc header beat", first_sop, 64'h1002_0048_5A01_0000);
        check("R3 rtc beats", mon_beats, 30);
        check("R3 rtc no gap", gap_max, 0);
        check("R3 rtc beat content", beat_err, 0);
        check("R6 last seq", last_seq, 2);
        check("R5 first payload bytes", last_b1, 64'h0203_0405_0607_0809);

        // IQ profile, fixed count 3
        run_fixed(1'b1, 3);
        rd(3'd2, v); check("R7 tx count iq", v, 3);
        check("R2 iq header beat", first_sop, 64'h1000_00F0_5A01_0000);
        check("R4 iq beats", mon_beats, 93);
        check("R4 iq gap min", gap_min, GAP);
        check("R4 iq gap max", gap_max, GAP);
        check("R4 iq content", beat_err, 0);

        // zero count
        run_fixed(1'b0, 0);
        rd(3'd2, v); check("R7 zero count tx", v, 0);
        check("R7 zero count seen", mon_pkts, 0);

        // continuous with random ready, then stop
        rdy_rand = 1'b1;
        mon_clear(1'b0);
        wr(3'd0, 16'h0005);
        repeat (400) @(negedge clk);
        wr(3'd0, 16'h000C);
        rd(3'd0, v); check("R12 mode ignored while busy", v, 32'h4);
        wr(3'd0, 16'h0002);
        wait_idle();
        check("R8 no partial packet", mon_idx, 0);
        rd(3'd2, v); check("R8 tx count equals seen", v, mon_pkts);
        check("R8 ran several", mon_pkts > 3, 1);
        check("R9 hold under stall", hold_err, 0);
        check("R9 cont content", beat_err, 0);
        rd(3'd3, v); check("R10 good equals sent", v, mon_pkts);

        // error injection
        rdy_rand = 1'b0;
        inject = 1'b1;
        run_fixed(1'b0, 1);
        inject = 1'b0;
        rd(3'd4, v); check("R11 bad count", v, 1);
        rd(3'd3, v); check("R11 good zero", v, 0);
        rd(3'd5, v); check("R11 sticky set", v[1], 1);
        wr(3'd0, 16'h0010);
        rd(3'd5, v); check("R11 sticky cleared", v[1], 0);
        rd(3'd4, v); check("R11 bad kept", v, 1);

        // random mix
        rdy_rand = 1'b1;
        for (int it = 0; it < 8; it++) begin
            bit iq;
            int n;
            iq = 1'($urandom % 2);
            n = 1 + int'($urandom % 5);
            run_fixed(iq, n);
            rd(3'd2, v); check("R7 random tx count", v, n);
            rd(3'd3, v); check("R10 random good", v, n);
            check("R5 random content", beat_err, 0);
            check("R6 random last seq", last_seq, n - 1);
            check("R9 random hold", hold_err, 0);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule